// File: doc/BRIEF.md
# Phase-Shifted Triangle-Carrier PWM for an Odd Cell Count

This block produces the on/off states for one converter leg made of 2N+1 half-bridge cells: N cells in the upper arm, N in the lower arm and one cell between them. Each cell has its own triangular carrier. All carriers share one period and are spread evenly over that period, so consecutive carriers sit 360/(2N+1) degrees apart. With the default N=2 there are five carriers, 72 degrees apart. Each cell compares its carrier with its own signed reference word. That word is supplied from outside and already includes the common sinusoid and any balancing corrections.

The carrier amplitude follows from a span input S. Each carrier is a triangle that steps by one count per clock between -A and +A, with A = S*(2N+1). One period therefore lasts 4A clocks, and the phase step is 4S clocks, which keeps every offset an exact number of clocks. References use the same units as the carriers. They are captured into shadow registers when a run starts and at every peak of the middle carrier, so a new reference only takes effect at the start of a period. The upper arm uses inverted compare polarity. When the reference equals the carrier, the cell keeps its previous state.

Top module: `psc_pwm_gen`

## Requirements
- R1: After reset every `cell_on` bit is 0 and `carrier_peak` is 0.
- R2: Cell index k is encoded as follows: k=0 is the middle cell, k=1..N are the upper-arm cells and k=N+1..2N are the lower-arm cells. The run starts on the first rising clock edge with `enable` high while idle. Let j be the number of clocks since that edge. Carrier k then has the triangle value at position u = (j + 4*k*S) mod 4A. That value is u-A when u <= 2A, and 3A-u otherwise.
- R3: For the middle and lower-arm cells, `cell_on[k]` becomes 1 on the next edge when the shadow reference is greater than the carrier, and 0 when the carrier is greater.
- R4: For the upper-arm cells, `cell_on[k]` becomes 0 on the next edge when the shadow reference is greater than the carrier, and 1 when the carrier is greater.
- R5: When a cell's shadow reference equals its carrier, that cell's output keeps its previous value.
- R6: The reference for cell k is the two's-complement field `cell_ref[k*REF_W +: REF_W]`. It is copied to that cell's shadow on the run-start edge, and on every edge where `carrier_peak` is high. At any other edge a change on `cell_ref` has no effect.
- R7: `carrier_peak` is high for exactly the clocks in which the middle carrier equals +A during a run.
- R8: On an edge where `enable` is sampled low, every `cell_on` bit becomes 0 and the run stops. When `enable` returns, all carriers restart from their initial phases as in R2.
- R9: S is taken from `carrier_span` at run start and held for the whole run; changes to `carrier_span` while running have no effect. A `carrier_span` value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low holds carriers at their start phase and forces all cells off |
| carrier_span | input | SPAN_W | Span S; carrier amplitude A = S*(2N+1) |
| cell_ref | input | (2N+1)*REF_W | Signed reference per cell, cell k in bits k*REF_W +: REF_W |
| cell_on | output | 2N+1 | Registered cell state, 1 = on |
| carrier_peak | output | 1 | High while the middle carrier is at +A |

## Verification
The bench aims at the exact compare boundary. It uses references of 0 and ±A, which the carriers reach exactly. A design that treated equality as greater-than would toggle on those cycles instead of holding. References at ±(A+1) force a cell fully on or fully off, and a polarity swap between the arms shows up there at once.

References are changed on every cycle, not just at peaks. A design that skipped the shadow stage would then switch mid-period, and one that latched one cycle late would use the wrong word for a whole period. Restarts after `enable` drops and runs started with a span of 0 check the phase offsets. Changing the span while running checks it is ignored. Any off-by-one in the start count or the ramp turn-around would shift every later edge and peak strobe.

// File: rtl/psc_pwm_pkg.sv
package psc_pwm_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } ramp_dir_t;

    // cell index map: 0 middle, 1..n upper arm, n+1..2n lower arm
    function automatic bit is_upper_cell(int k, int n);
        return (k >= 1) && (k <= n);
    endfunction

endpackage

// File: rtl/psc_carrier.sv
module psc_carrier
    import psc_pwm_pkg::*;
#(
    parameter int SPAN_W = 6,
    parameter int CNT_W  = 12,
    parameter int CELLS  = 5,
    parameter int IDX    = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [SPAN_W-1:0]       span_init,
    input  logic signed [CNT_W-1:0] amp,
    output logic signed [CNT_W-1:0] value
);

    typedef struct packed {
        logic signed [CNT_W-1:0] cnt;
        ramp_dir_t               dir;
    } ramp_t;

    ramp_t st_d, st_q;
    logic [CNT_W-1:0] amp_init;
    logic [CNT_W-1:0] t_off;

    always_comb begin
        amp_init = CNT_W'(span_init) * CNT_W'(CELLS);
        t_off    = CNT_W'(4 * IDX) * CNT_W'(span_init);
        st_d     = st_q;
        if (load) begin
            // place the ramp at its phase offset of t_off clocks
            if (t_off <= (amp_init << 1)) begin
                st_d.cnt = signed'(t_off - amp_init);
                st_d.dir = DIR_UP;
            end else begin
                st_d.cnt = signed'(CNT_W'(3) * amp_init - t_off);
                st_d.dir = DIR_DOWN;
            end
        end else if (st_q.dir == DIR_UP) begin
            if (st_q.cnt == amp) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
                st_d.dir = DIR_DOWN;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else begin
            if (st_q.cnt == -amp) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                st_d.dir = DIR_UP;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir: DIR_UP};
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.cnt;

endmodule

// File: rtl/psc_cell_cmp.sv
module psc_cell_cmp #(
    parameter int REF_W  = 12,
    parameter int CNT_W  = 12,
    parameter bit INVERT = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    load,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic signed [CNT_W-1:0] carrier,
    output logic                    cell_on,
    output logic signed [REF_W-1:0] shadow
);

    typedef struct packed {
        logic signed [REF_W-1:0] shadow;
        logic                    on;
    } cmp_t;

    cmp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.shadow = ref_in;
        end
        if (clear) begin
            st_d.on = 1'b0;
        end else if (st_q.shadow > carrier) begin
            st_d.on = ~INVERT;
        end else if (carrier > st_q.shadow) begin
            st_d.on = INVERT;
        end
        // equal: hold previous state
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cell_on = st_q.on;
    assign shadow  = st_q.shadow;

endmodule

// File: rtl/psc_pwm_gen.sv
module psc_pwm_gen
    import psc_pwm_pkg::*;
#(
    parameter int N_ARM  = 2,
    parameter int SPAN_W = 6,
    parameter int REF_W  = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable,
    input  logic [SPAN_W-1:0]             carrier_span,
    input  logic [(2*N_ARM+1)*REF_W-1:0]  cell_ref,
    output logic [2*N_ARM:0]              cell_on,
    output logic                          carrier_peak
);

    localparam int CELLS   = 2 * N_ARM + 1;
    localparam int AMP_MAX = (2 ** SPAN_W - 1) * CELLS;
    localparam int CNT_W   = $clog2(4 * AMP_MAX + 1) + 1;

    typedef struct packed {
        logic              run;
        logic [SPAN_W-1:0] span;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [SPAN_W-1:0]       span_eff;
    logic signed [CNT_W-1:0] amp;
    logic                    active;
    logic                    shadow_load;
    logic signed [CNT_W-1:0] car    [CELLS];
    logic signed [REF_W-1:0] shadow [CELLS];

    always_comb begin
        span_eff    = (carrier_span == '0) ? SPAN_W'(1) : carrier_span;
        amp         = signed'(CNT_W'(st_q.span) * CNT_W'(CELLS));
        active      = st_q.run && enable;
        carrier_peak = st_q.run && (car[0] == amp);
        shadow_load = !st_q.run || (active && carrier_peak);
        st_d.run    = enable;
        st_d.span   = st_q.run ? st_q.span : span_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, span: SPAN_W'(1)};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        psc_carrier #(
            .SPAN_W (SPAN_W),
            .CNT_W  (CNT_W),
            .CELLS  (CELLS),
            .IDX    (k)
        ) u_carrier (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (!active),
            .span_init (span_eff),
            .amp       (amp),
            .value     (car[k])
        );

        psc_cell_cmp #(
            .REF_W  (REF_W),
            .CNT_W  (CNT_W),
            .INVERT (is_upper_cell(k, N_ARM))
        ) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (!active),
            .load    (shadow_load),
            .ref_in  (cell_ref[k*REF_W +: REF_W]),
            .carrier (car[k]),
            .cell_on (cell_on[k]),
            .shadow  (shadow[k])
        );
    end

endmodule

// File: rtl/psc_pwm_chk.sv
module psc_pwm_chk
    import psc_pwm_pkg::*;
#(
    parameter int N_ARM = 2,
    parameter int CNT_W = 12,
    parameter int REF_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    enable,
    input logic                    run_q,
    input logic signed [CNT_W-1:0] amp,
    input logic signed [CNT_W-1:0] car    [2*N_ARM+1],
    input logic signed [REF_W-1:0] shadow [2*N_ARM+1],
    input logic [2*N_ARM:0]        cell_on,
    input logic                    carrier_peak
);

    localparam int CELLS = 2 * N_ARM + 1;

    assert_idle_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cell_on == '0));

    assert_peak_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_peak |=> !carrier_peak);

    assert_carrier_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> ((car[0] <= amp) && (car[0] >= -amp)));

    assert_carrier_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_q) && $past(enable)) |->
            ((car[0] == $past(car[0]) + CNT_W'(1)) || (car[0] == $past(car[0]) - CNT_W'(1))));

    for (genvar k = 0; k < CELLS; k++) begin : g_pol
        if (is_upper_cell(k, N_ARM)) begin : g_up
            assert_upper_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(cell_on[k]) |-> ($past(car[k]) > $past(shadow[k])));
        end else begin : g_dn
            assert_mid_low_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(cell_on[k]) |-> ($past(shadow[k]) > $past(car[k])));
        end
        assert_equal_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(run_q) && $past(enable) && ($past(shadow[k]) == $past(car[k])))
                |-> $stable(cell_on[k]));
    end

endmodule

bind psc_pwm_gen psc_pwm_chk #(
    .N_ARM (N_ARM),
    .CNT_W (CNT_W),
    .REF_W (REF_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .run_q        (st_q.run),
    .amp          (amp),
    .car          (car),
    .shadow       (shadow),
    .cell_on      (cell_on),
    .carrier_peak (carrier_peak)
);

// File: tb/tb_psc_pwm_gen.sv
module tb_psc_pwm_gen;

    localparam int CLK_PERIOD = 10;
    localparam int N_ARM      = 2;
    localparam int SPAN_W     = 6;
    localparam int REF_W      = 12;
    localparam int CELLS      = 2 * N_ARM + 1;
    localparam int WATCHDOG   = 100000;

    logic                     clk;
    logic                     rst_n;
    logic                     enable;
    logic [SPAN_W-1:0]        carrier_span;
    logic [CELLS*REF_W-1:0]   cell_ref;
    logic [CELLS-1:0]         cell_on;
    logic                     carrier_peak;

    psc_pwm_gen #(.N_ARM(N_ARM), .SPAN_W(SPAN_W), .REF_W(REF_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .carrier_span (carrier_span),
        .cell_ref     (cell_ref),
        .cell_on      (cell_on),
        .carrier_peak (carrier_peak)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    string sec     = "R2";

    // spec model
    bit m_run  = 1'b0;
    int m_span = 1;
    int m_t    = 0;
    int m_sh  [CELLS];
    bit m_out [CELLS];

    function automatic bit upper(int k);
        return (k >= 1) && (k <= N_ARM);
    endfunction

    function automatic int tri_val(int k, int t, int span);
        int a, u;
        a = span * CELLS;
        u = (t + 4 * k * span) % (4 * a);
        return (u <= 2 * a) ? (u - a) : (3 * a - u);
    endfunction

    function automatic int ref_of(int k);
        return int'($signed(cell_ref[k*REF_W +: REF_W]));
    endfunction

    function automatic string tag_for(int k);
        if (sec == "RND") return upper(k) ? "R4" : "R3";
        return sec;
    endfunction

    function automatic int cur_amp();
        return ((carrier_span == 0) ? 1 : int'(carrier_span)) * CELLS;
    endfunction

    function automatic int rnd_ref(int a);
        return int'($urandom_range(2 * a + 4)) - a - 2;
    endfunction

    task automatic set_ref(int k, int v);
        cell_ref[k*REF_W +: REF_W] = REF_W'(v);
    endtask

    task automatic model_step();
        int a, c;
        bit pk;
        if (!m_run) begin
            m_t    = 0;
            m_span = (carrier_span == 0) ? 1 : int'(carrier_span);
            for (int k = 0; k < CELLS; k++) begin
                m_sh[k]  = ref_of(k);
                m_out[k] = 1'b0;
            end
            m_run = enable;
        end else if (!enable) begin
            m_run = 1'b0;
            for (int k = 0; k < CELLS; k++) m_out[k] = 1'b0;
        end else begin
            a  = m_span * CELLS;
            pk = (tri_val(0, m_t, m_span) == a);
            for (int k = 0; k < CELLS; k++) begin
                c = tri_val(k, m_t, m_span);
                if (m_sh[k] > c) m_out[k] = !upper(k);
                else if (c > m_sh[k]) m_out[k] = upper(k);
            end
            if (pk) for (int k = 0; k < CELLS; k++) m_sh[k] = ref_of(k);
            m_t = (m_t + 1) % (4 * a);
        end
    endtask

    task automatic check_outputs();
        bit             exp_pk;
        logic [CELLS-1:0] exp_on;
        exp_pk = m_run ? (tri_val(0, m_t, m_span) == m_span * CELLS) : 1'b0;
        n_tests++;
        if (carrier_peak !== exp_pk) begin
            n_fail++;
            $display("FAIL R7 carrier_peak actual %0b expected %0b (t=%0d)", carrier_peak, exp_pk, m_t);
        end
        for (int k = 0; k < CELLS; k++) exp_on[k] = m_out[k];
        n_tests++;
        if (cell_on !== exp_on) begin
            n_fail++;
            for (int k = 0; k < CELLS; k++)
                if (cell_on[k] !== exp_on[k])
                    $display("FAIL %s cell %0d actual %0b expected %0b (t=%0d)",
                             tag_for(k), k, cell_on[k], exp_on[k], m_t);
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired: actual %0d cycles expected fewer", WATCHDOG);
        finish_run();
    end

    initial begin
        int a;
        void'($urandom(32'd20240611));
        rst_n        = 1'b0;
        enable       = 1'b0;
        carrier_span = SPAN_W'(3);
        cell_ref     = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        n_tests++;
        if (cell_on !== '0 || carrier_peak !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 after reset actual on=%b peak=%b expected on=0 peak=0", cell_on, carrier_peak);
        end

        // R2: phase layout seen through zero references
        sec    = "R2";
        enable = 1'b1;
        repeat (200) tick();

        // R3 / R4: random references over several spans
        sec = "RND";
        for (int it = 0; it < 6; it++) begin
            enable = 1'b0;
            tick();
            carrier_span = SPAN_W'($urandom_range(1, 8));
            enable = 1'b1;
            a = cur_amp();
            for (int c = 0; c < 150; c++) begin
                for (int k = 0; k < CELLS; k++) set_ref(k, rnd_ref(a));
                tick();
            end
        end

        // R5: references exactly reachable by the carriers
        sec = "R5";
        enable = 1'b0;
        tick();
        carrier_span = SPAN_W'(2);
        a = cur_amp();
        set_ref(0, 0);  set_ref(1, a);  set_ref(2, -a);
        set_ref(3, 3);  set_ref(4, -a);
        enable = 1'b1;
        repeat (200) tick();

        // R6: references change every cycle, only peak samples count
        sec = "R6";
        for (int c = 0; c < 300; c++) begin
            for (int k = 0; k < CELLS; k++) set_ref(k, (c % 2 == 0) ? a + 1 : -a - 1 + k);
            tick();
        end

        // R9: span zero, then span changes while running
        sec = "R9";
        enable = 1'b0;
        tick();
        carrier_span = '0;
        for (int k = 0; k < CELLS; k++) set_ref(k, k - 2);
        enable = 1'b1;
        repeat (100) tick();
        carrier_span = SPAN_W'(7);
        repeat (100) tick();

        // R8: enable dropping at arbitrary points
        sec = "R8";
        carrier_span = SPAN_W'(4);
        for (int c = 0; c < 400; c++) begin
            enable = ($urandom_range(7) != 0);
            a = cur_amp();
            for (int k = 0; k < CELLS; k++) set_ref(k, rnd_ref(a));
            tick();
        end

        finish_run();
    end

endmodule